// File: doc/BRIEF.md
# APB Dual-Timer Register Wrapper with Integration-Test Mode

This block sits between an APB bus and two identical timer channels whose counting logic lives elsewhere. It decodes a 4 KB register window. The lowest 64 bytes are routed to the channels: address bit 5 picks the channel and bits 4:2 pick one of seven channel registers. The wrapper passes each channel a one-cycle access strobe, the register index, the write flag and the write data. It returns the selected channel's read word on PRDATA.

Near the top of the window the wrapper keeps two small registers of its own. The test-control register switches the interrupt outputs from the channels' real interrupt lines to the bits of the test-output register, so that board-level wiring can be exercised without running a timer. Twelve read-only identification bytes fill the last words of the window. Every other address reads as zero and ignores writes.

The wrapper drives one interrupt per channel and a combined interrupt. Every transfer completes in its access phase with no wait state and no error response.

Top module: `dt_apb_wrap`

## Requirements
- R1: After reset, test mode is off and the test-output bits are 0. Each `irq_out[i]` then follows `ch_irq_in[i]`, `pready` is 1 and `pslverr` is 0.
- R2: An access to byte offsets 0x00–0x3F raises `ch_req[paddr[5]]` for exactly its access phase, when `psel` and `penable` are both high. During that access `ch_reg` = `paddr[4:2]`, `ch_write` = `pwrite` and `ch_wdata` = `pwdata`. Only register indices 0–6 (offsets 0x00–0x18 within a channel) are mapped. Index 7 (offsets 0x1C and 0x3C) raises no strobe.
- R3: A read of a mapped channel register returns that channel's 32-bit word from `ch_rdata`. Channel 0 occupies bits 31:0 and channel 1 occupies bits 63:32.
- R4: A write to offset 0xF00 stores `pwdata[0]` as the test-mode enable and discards all other bits.
- R5: A write to offset 0xF04 stores `pwdata[1:0]`. While test mode is on, `irq_out[0]` = bit 0 and `irq_out[1]` = bit 1. While it is off, `irq_out` = `ch_irq_in`. A change of source takes effect on the clock edge that ends the write.
- R6: `irq_any` is the OR of both bits of `irq_out`.
- R7: The word at byte offset 0xFD0 + 4*k, for k = 0..11, reads as a zero-extended byte from this list: 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to these offsets have no effect.
- R8: Reads of offsets that are not mapped return 0. This includes 0x40–0xEFC, 0xF08–0xFCC, the index-7 channel slots, and the write-only registers at 0xF00 and 0xF04. Writes to unmapped offsets change no state and raise no channel strobe.
- R9: The setup phase of a transfer, when `psel` is high and `penable` is low, raises no channel strobe and writes no register.
- R10: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while a read is selected |
| pready | output | 1 | Transfer done, constant 1 |
| pslverr | output | 1 | Error response, constant 0 |
| ch_req | output | 2 | Per-channel access strobe |
| ch_write | output | 1 | Direction of the channel access |
| ch_reg | output | 3 | Register index within the channel |
| ch_wdata | output | 32 | Write data to the channel |
| ch_rdata | input | 64 | Read words from both channels |
| ch_irq_in | input | 2 | Real interrupt lines of the channels |
| irq_out | output | 2 | Per-channel interrupt outputs |
| irq_any | output | 1 | Combined interrupt output |

## Verification
Two events can land in the same cycle: a write that turns test mode off, and a change on the channels' real interrupt lines. The bench changes `ch_irq_in` in the very access phase of the write that clears the test-control register. It checks that `irq_out` still shows the test-output bits before the edge and shows the new channel lines right after it, with `irq_any` following. A full sweep of all 1024 word offsets then compares every read against an address-computed expectation, and a write sweep over all unmapped offsets confirms that the test state held in the interrupt outputs survives.

// File: rtl/dt_pkg.sv
package dt_pkg;

  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned ID_COUNT = 12;
  localparam logic [11:0] TCTRL_OFS = 12'hF00;
  localparam logic [11:0] TOUT_OFS  = 12'hF04;
  localparam logic [11:0] ID_BASE   = 12'hFD0;

  // Region of the window a word address falls in
  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_CHAN,
    RGN_TCTRL,
    RGN_TOUT,
    RGN_ID
  } rgn_e;

  // Identification byte k, counted from ID_BASE upward in words
  function automatic logic [7:0] id_byte(input logic [3:0] k);
    case (k)
      4'd0:  id_byte = 8'h04;
      4'd4:  id_byte = 8'h23;
      4'd5:  id_byte = 8'hB8;
      4'd6:  id_byte = 8'h1B;
      4'd8:  id_byte = 8'h0D;
      4'd9:  id_byte = 8'hF0;
      4'd10: id_byte = 8'h05;
      4'd11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/dt_decode.sv
module dt_decode
  import dt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-3:0] waddr,
  output rgn_e              rgn,
  output logic [CH_W-1:0]   ch,
  output logic [2:0]        reg_idx,
  output logic [3:0]        id_idx
);

  localparam logic [ADDR_W-3:0] TCTRL_W = TCTRL_OFS[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] TOUT_W  = TOUT_OFS[ADDR_W-1:2];
  localparam logic [ADDR_W-3:0] ID_W    = ID_BASE[ADDR_W-1:2];

  assign ch      = waddr[3 +: CH_W];
  assign reg_idx = waddr[2:0];
  assign id_idx  = waddr[3:0] - 4'd4;

  always_comb begin
    rgn = RGN_NONE;
    if (waddr[ADDR_W-3:3+CH_W] == '0) begin
      if (reg_idx != 3'd7 && int'(ch) < int'(NUM_CH)) rgn = RGN_CHAN;
    end else if (waddr == TCTRL_W) begin
      rgn = RGN_TCTRL;
    end else if (waddr == TOUT_W) begin
      rgn = RGN_TOUT;
    end else if (waddr >= ID_W) begin
      rgn = RGN_ID;
    end
  end

endmodule

// File: rtl/dt_chan_route.sv
module dt_chan_route #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     access,
  input  logic                     hit,
  input  logic [CH_W-1:0]          ch,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
  output logic [NUM_CH-1:0]        ch_req,
  output logic [DATA_W-1:0]        sel_rdata
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_req
    assign ch_req[i] = access && hit && (ch == CH_W'(i));
  end

  always_comb begin
    sel_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch == CH_W'(i)) sel_rdata = ch_rdata[i*DATA_W +: DATA_W];
    end
  end

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_req)); // R2

  AST_STROBE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req != '0) |-> access); // R2

endmodule

// File: rtl/dt_test_ctl.sv
module dt_test_ctl #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_out,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] ch_irq_in,
  output logic [NUM_CH-1:0] irq_out,
  output logic              irq_any
);

  logic              test_en;
  logic [NUM_CH-1:0] test_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_en   <= 1'b0;
      test_bits <= '0;
    end else begin
      if (wr_ctrl) test_en   <= wbits[0];
      if (wr_out)  test_bits <= wbits;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_irq
    assign irq_out[i] = test_en ? test_bits[i] : ch_irq_in[i];
  end

  assign irq_any = |irq_out;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(test_en)); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out |=> $stable(test_bits)); // R5

  AST_OFF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !test_en) |=> (irq_out == ch_irq_in)); // R5

endmodule

// File: rtl/dt_apb_wrap.sv
module dt_apb_wrap
  import dt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     pclk,
  input  logic                     presetn,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [DATA_W-1:0]        pwdata,
  output logic [DATA_W-1:0]        prdata,
  output logic                     pready,
  output logic                     pslverr,
  output logic [NUM_CH-1:0]        ch_req,
  output logic                     ch_write,
  output logic [2:0]               ch_reg,
  output logic [DATA_W-1:0]        ch_wdata,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
  input  logic [NUM_CH-1:0]        ch_irq_in,
  output logic [NUM_CH-1:0]        irq_out,
  output logic                     irq_any
);

  rgn_e              rgn;
  logic [CH_W-1:0]   ch;
  logic [2:0]        reg_idx;
  logic [3:0]        id_idx;
  logic [DATA_W-1:0] sel_rdata;
  logic              access;
  logic              wr_ctrl;
  logic              wr_out;
  logic              unused_lsb;

  assign unused_lsb = ^paddr[1:0];
  assign access     = psel && penable;
  assign wr_ctrl    = access && pwrite && (rgn == RGN_TCTRL);
  assign wr_out     = access && pwrite && (rgn == RGN_TOUT);

  assign pready   = 1'b1;
  assign pslverr  = 1'b0;
  assign ch_write = pwrite;
  assign ch_reg   = reg_idx;
  assign ch_wdata = pwdata;

  dt_decode #(.NUM_CH(NUM_CH)) u_dec (
    .waddr   (paddr[ADDR_W-1:2]),
    .rgn     (rgn),
    .ch      (ch),
    .reg_idx (reg_idx),
    .id_idx  (id_idx)
  );

  dt_chan_route #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_route (
    .clk       (pclk),
    .rst_n     (presetn),
    .access    (access),
    .hit       (rgn == RGN_CHAN),
    .ch        (ch),
    .ch_rdata  (ch_rdata),
    .ch_req    (ch_req),
    .sel_rdata (sel_rdata)
  );

  dt_test_ctl #(.NUM_CH(NUM_CH)) u_test (
    .clk       (pclk),
    .rst_n     (presetn),
    .wr_ctrl   (wr_ctrl),
    .wr_out    (wr_out),
    .wbits     (pwdata[NUM_CH-1:0]),
    .ch_irq_in (ch_irq_in),
    .irq_out   (irq_out),
    .irq_any   (irq_any)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (rgn)
        RGN_CHAN: prdata = sel_rdata;
        RGN_ID:   prdata = {{(DATA_W-8){1'b0}}, id_byte(id_idx)};
        default:  prdata = '0;
      endcase
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && rgn != RGN_CHAN && rgn != RGN_ID) |-> (prdata == '0)); // R8

  AST_SETUP_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable) |-> (ch_req == '0)); // R9

  AST_ANY_MATCH: assert property (@(posedge pclk) disable iff (!presetn)
    irq_any == (irq_out != '0)); // R6

endmodule

// File: tb/sim_dt_apb_wrap.sv
module sim_dt_apb_wrap;

  logic        clk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [1:0]  ch_req;
  logic        ch_write;
  logic [2:0]  ch_reg;
  logic [31:0] ch_wdata;
  logic [63:0] ch_rdata;
  logic [1:0]  ch_irq_in = 2'b00;
  logic [1:0]  irq_out;
  logic        irq_any;

  always #5 clk = ~clk;

  // Channel models: a recognisable word per channel and register index
  assign ch_rdata = {32'hA100_0000 | {29'd0, ch_reg}, 32'hA000_0000 | {29'd0, ch_reg}};

  dt_apb_wrap u0 (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .ch_req(ch_req), .ch_write(ch_write), .ch_reg(ch_reg), .ch_wdata(ch_wdata),
    .ch_rdata(ch_rdata), .ch_irq_in(ch_irq_in), .irq_out(irq_out), .irq_any(irq_any)
  );

  localparam logic [7:0] IDS [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                                      8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit in_chan(input logic [11:0] a);
    return (a < 12'h040) && (a[4:2] != 3'd7);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a < 12'h040) begin
      if (a[4:2] == 3'd7) return 32'd0;
      return 32'hA000_0000 + (32'(a[5]) << 24) + 32'(a[4:2]);
    end
    if (a >= 12'hFD0) return 32'(IDS[(int'(a) - 'hFD0) / 4]);
    return 32'd0;
  endfunction

  logic [31:0] r_data, r_wd;
  logic [1:0]  r_req;
  logic [2:0]  r_reg;
  logic        r_wr;

  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    r_data = prdata; r_req = ch_req; r_reg = ch_reg; r_wr = ch_write; r_wd = ch_wdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    ch_irq_in = 2'b10;
    presetn = 1'b1;
    @(negedge clk); #1;
    chk("R1 irq follows channels", 32'(irq_out), 32'h2);
    chk("R1 pready", 32'(pready), 32'h1);
    chk("R1 pslverr", 32'(pslverr), 32'h0);
    // Turn test mode on only: test bits must still be zero from reset
    apb(1'b1, 12'hF00, 32'h1);
    #1;
    chk("R1 test bits reset", 32'(irq_out), 32'h0);
    apb(1'b1, 12'hF00, 32'h0);

    // R4 R5 R6: exhaustive over enable, test bits, channel lines
    for (int en = 0; en < 2; en++) begin
      for (int tb = 0; tb < 4; tb++) begin
        for (int ci = 0; ci < 4; ci++) begin
          apb(1'b1, 12'hF04, 32'hFFFF_FFF0 | 32'(tb));
          apb(1'b1, 12'hF00, en[0] ? 32'h1 : 32'hFFFF_FFFE);
          ch_irq_in = 2'(ci);
          #1;
          chk(en[0] ? "R4 R5 test route" : "R5 channel route", 32'(irq_out),
              en[0] ? 32'(tb) : 32'(ci));
          chk("R6 combined", 32'(irq_any), (en[0] ? (tb != 0) : (ci != 0)) ? 32'h1 : 32'h0);
        end
      end
    end

    // Same-cycle: test mode cleared while channel lines change
    apb(1'b1, 12'hF04, 32'h3);
    apb(1'b1, 12'hF00, 32'h1);
    ch_irq_in = 2'b00;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'hF00; pwdata = 32'h0;
    @(negedge clk);
    penable = 1'b1; ch_irq_in = 2'b01;
    #1;
    chk("R5 before edge", 32'(irq_out), 32'h3);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #1;
    chk("R5 after edge", 32'(irq_out), 32'h1);
    chk("R6 after edge", 32'(irq_any), 32'h1);

    // R9: setup phase only, no access phase
    apb(1'b1, 12'hF04, 32'h2);
    apb(1'b1, 12'hF00, 32'h1);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'hF04; pwdata = 32'h1;
    #1; chk("R9 no strobe in setup", 32'(ch_req), 32'h0);
    @(negedge clk);
    paddr = 12'h024;
    #1; chk("R9 no channel strobe in setup", 32'(ch_req), 32'h0);
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    #1; chk("R9 test bits unchanged", 32'(irq_out), 32'h2);

    // R8 R7: writes to every unmapped and ID offset leave state alone
    ch_irq_in = 2'b01;
    for (int w = 0; w < 1024; w++) begin
      logic [11:0] a;
      a = 12'(w * 4);
      if (a < 12'h040 && a[4:2] != 3'd7) continue;
      if (a == 12'hF00 || a == 12'hF04) continue;
      apb(1'b1, a, 32'hFFFF_FFFF);
      if (r_req != 2'b00) chk("R8 no strobe on unmapped write", 32'(r_req), 32'h0);
    end
    #1;
    chk("R8 R7 state after write sweep", 32'(irq_out), 32'h2);
    chk("R8 combined after sweep", 32'(irq_any), 32'h1);

    // R2: write sweep of the channel window
    for (int w = 0; w < 16; w++) begin
      logic [11:0] a;
      a = 12'(w * 4);
      apb(1'b1, a, 32'h5A00_0000 | 32'(a));
      chk("R2 write strobe", 32'(r_req), in_chan(a) ? (32'h1 << a[5]) : 32'h0);
      if (in_chan(a)) begin
        chk("R2 reg index", 32'(r_reg), 32'(a[4:2]));
        chk("R2 write flag", 32'(r_wr), 32'h1);
        chk("R2 write data", r_wd, 32'h5A00_0000 | 32'(a));
      end
    end

    // R3 R7 R8: read sweep of the whole window
    for (int w = 0; w < 1024; w++) begin
      logic [11:0] a;
      a = 12'(w * 4);
      apb(1'b0, a, 32'h0);
      if (a < 12'h040) chk("R3 channel read", r_data, exp_rd(a));
      else if (a >= 12'hFD0) chk("R7 id read", r_data, exp_rd(a));
      else chk("R8 unmapped read", r_data, 32'h0);
      chk("R2 read strobe", 32'(r_req), in_chan(a) ? (32'h1 << a[5]) : 32'h0);
      if (in_chan(a)) chk("R2 read flag", 32'(r_wr), 32'h0);
    end
    chk("R10 pready", 32'(pready), 32'h1);
    chk("R10 pslverr", 32'(pslverr), 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule